// File: doc/BRIEF.md
# E1 Timeslot-0 Framer with CRC-4 Multiframe Insertion

This block sits in the transmit path of an E1 line. Payload arrives as one byte per timeslot, 32 timeslots per frame. The block leaves every byte outside timeslot 0 untouched. It rewrites timeslot 0 to form either plain alignment frames or a 16-frame CRC-4 multiframe. It inserts these fields:

- the alignment word and the non-alignment marker;
- the international and remote-alarm bits;
- the five spare bits;
- the multiframe pattern, the CRC-4 check bits and the far-end error bits.

A strobe on the input marks timeslot 0 of frame 0 and forces the internal position counters to that point. Each result appears on the output one clock after its input byte.

In CRC-4 operation, the check bits sent during each half-multiframe (8 frames) are the remainder of the previous half. The remainder is computed over the bytes as they leave the block, with the check-bit positions zeroed. Far-end error bits report CRC errors seen by the receiver. Each receive error event queues a single zero for the matching half. For test-pattern work, single-shot requests invert a chosen field exactly once. A request is held until that field next goes out, and is then cleared.

The bit numbering follows the line order: bit 1 is the first bit sent and is carried in `inByte[7]`, and bit 8 is `inByte[0]`. In even frames (frame number 0, 2, ...) timeslot 0 holds the alignment word. In odd frames it holds the non-alignment data.

Top module: `e1_ts0_framer`

## Requirements
- R1: `outValid` is `inValid` delayed by one clock. Each output byte is the input byte of the previous clock, changed only as listed below. Bytes outside timeslot 0 are never changed. With `mode`=3 (pass) no byte is changed. After reset, `outValid`=0 and `outByte`=0.
- R2: In modes 0 (basic) and 1 (CRC-4), even-frame timeslot 0 carries `0011011` in `outByte[6:0]` and odd-frame timeslot 0 has `outByte[6]`=1. A `frameSync` pulse on a valid byte marks that byte as timeslot 0 of frame 0.
- R3: In mode 0 with `siEnable`=1, `outByte[7]` of timeslot 0 is `siAlign` in even frames and `siNonAlign` in odd frames. With `siEnable`=0 it is the input bit.
- R4: In modes 0 and 1, odd-frame `outByte[5]` is 1 when `raiManual`=1, or when both `raiAuto` and `rxAlarm` are 1. Otherwise it is the input bit.
- R5: In modes 0, 1 and 2, odd-frame `outByte[i]` (i=0..4, where i=4 is Sa4 and i=0 is Sa8) equals `saValue[i]` when `saEnable[i]`=1. Otherwise it is the input bit.
- R6: In mode 1, `outByte[7]` of odd frames 1, 3, 5, 7, 9 and 11 carries 0, 0, 1, 0, 1, 1 in that order.
- R7: In modes 1 and 2, `outByte[7]` of even frames 0, 2, 4 and 6 of each half-multiframe (frames 0-7 or 8-15) carries C1 to C4. These are the remainder bits 3 down to 0 of the previous half-multiframe's output bits, sent MSB first through x^4+x+1, starting from zero, with the C positions taken as 0.
- R8: In mode 1 with `eSelect`=0, `outByte[7]` is 1 in frame 13 (E1) and in frame 15 (E2). A `rxCrcErr` pulse with `rxCrcErrSmf`=0 (first half) or 1 (second half) makes the next E1 or E2, respectively, a single 0.
- R9: In mode 1 with `eSelect`=1, E1 is `siAlign` and E2 is `siNonAlign`. With `eSelect`=2 or 3, both E positions pass the input bit.
- R10: A pulse on `invFasWordReq` inverts all seven bits of the next alignment word sent. A pulse on `invFasBitReq` inverts only `outByte[0]` of the next word. Later words are normal.
- R11: A pulse on `invNfasReq` makes the next odd-frame `outByte[6]` a 0, once.
- R12: A pulse on `invMfasReq` inverts all six multiframe-pattern bits of the next multiframe in mode 1, once.
- R13: A pulse on `invCrcReq` inverts all four check bits of the next half-multiframe whose remainder is latched in modes 1 or 2, once.
- R14: In mode 2 (modified CRC-4), only the C positions and the enabled spare bits change. All other timeslot-0 bits pass from the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| frameSync | input | 1 | Marks current byte as timeslot 0 of frame 0 |
| inByte | input | 8 | Payload byte, bit 7 sent first |
| mode | input | 2 | 0 basic, 1 CRC-4, 2 modified CRC-4, 3 pass |
| siEnable | input | 1 | Enable international-bit insertion (basic) |
| siAlign | input | 1 | International bit for alignment frames / E1 source |
| siNonAlign | input | 1 | International bit for non-alignment frames / E2 source |
| raiManual | input | 1 | Force remote alarm bit to 1 |
| raiAuto | input | 1 | Let `rxAlarm` drive the remote alarm bit |
| rxAlarm | input | 1 | Receive-side alarm condition |
| saEnable | input | 5 | Per-position spare-bit enable (bit 4 = Sa4) |
| saValue | input | 5 | Spare-bit values |
| eSelect | input | 2 | E-bit source: 0 error events, 1 international bits, 2/3 unchanged |
| rxCrcErr | input | 1 | Receive CRC-4 error event pulse |
| rxCrcErrSmf | input | 1 | Half-multiframe of that event (0 first, 1 second) |
| invFasBitReq | input | 1 | One-shot: invert one alignment-word bit |
| invFasWordReq | input | 1 | One-shot: invert whole alignment word |
| invNfasReq | input | 1 | One-shot: invert non-alignment marker |
| invMfasReq | input | 1 | One-shot: invert multiframe pattern |
| invCrcReq | input | 1 | One-shot: invert one half-multiframe's check bits |
| outValid | output | 1 | Output byte valid |
| outByte | output | 8 | Framed byte |

## Verification
If the position counters slip, the alignment word shows up in the wrong byte or the wrong frame. That can be seen at the output within one frame of the `frameSync` byte. A wrong running remainder or latch point stays hidden until the next half-multiframe, when four check bits disagree with a remainder computed from the observed output. That takes up to 8 frames. A stuck or wrongly cleared one-shot or error flag shows as a missing or repeated inversion or zero in the next occurrence of its field. For the multiframe and E fields, that occurrence can be one multiframe away.

// File: rtl/e1fr_pkg.sv
package e1fr_pkg;
  localparam int TS_PER_FRAME  = 32;
  localparam int FRAMES_PER_MF = 16;
  localparam int TS_W          = $clog2(TS_PER_FRAME);
  localparam int FRM_W         = $clog2(FRAMES_PER_MF);
  localparam int CRC_W         = 4;
  localparam int SA_BITS       = 5;
  localparam logic [TS_W-1:0]  TS_LAST   = TS_W'(TS_PER_FRAME - 1);
  localparam logic [6:0]       FAS_WORD  = 7'b0011011;
  localparam logic [5:0]       MFAS_WORD = 6'b001011;
  localparam logic [CRC_W-1:0] CRC_POLY  = 4'b0011;

  typedef enum logic [1:0] {
    MODE_BASIC  = 2'd0,
    MODE_CRC4   = 2'd1,
    MODE_MODCRC = 2'd2,
    MODE_PASS   = 2'd3
  } frMode_e;

  typedef struct packed {
    logic             valid;
    logic             ts0;
    logic [FRM_W-1:0] frm;
    logic             smfStart;
    logic             smfEnd;
    logic             fasInvAll;
    logic             fasInvBit;
    logic             nfasInv;
    logic             mfasInv;
    logic             crcInv;
    logic             eZero;
  } frStrobe_t;
endpackage

// File: rtl/e1fr_ctrl.sv
module e1fr_ctrl
  import e1fr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      frameSync,
  input  frMode_e   mode,
  input  logic [1:0] eSelect,
  input  logic      rxCrcErr,
  input  logic      rxCrcErrSmf,
  input  logic      invFasBitReq,
  input  logic      invFasWordReq,
  input  logic      invNfasReq,
  input  logic      invMfasReq,
  input  logic      invCrcReq,
  output frStrobe_t stb
);
  logic [TS_W-1:0]  tsCnt, curTs;
  logic [FRM_W-1:0] frmCnt, curFrm;
  logic fasAllPend, fasBitPend, nfasPend, mfasPend, mfasLatch, crcPend;
  logic [1:0] errPend;
  logic ts0, evenFrm, smfEnd, framing, crcBits;
  logic useFasAll, useFasBit, takeNfas, takeMfas, takeCrc, eSlot1, eSlot2;

  assign curTs   = frameSync ? '0 : tsCnt;
  assign curFrm  = frameSync ? '0 : frmCnt;
  assign ts0     = inValid && (curTs == '0);
  assign evenFrm = ~curFrm[0];
  assign smfEnd  = inValid && (curTs == TS_LAST) && (curFrm[2:0] == 3'd7);
  assign framing = (mode == MODE_BASIC) || (mode == MODE_CRC4);
  assign crcBits = (mode == MODE_CRC4) || (mode == MODE_MODCRC);

  assign useFasAll = ts0 && evenFrm && framing && fasAllPend;
  assign useFasBit = ts0 && evenFrm && framing && !fasAllPend && fasBitPend;
  assign takeNfas  = ts0 && !evenFrm && framing;
  assign takeMfas  = ts0 && (curFrm == FRM_W'(1)) && (mode == MODE_CRC4);
  assign takeCrc   = smfEnd && crcBits;
  assign eSlot1    = ts0 && (curFrm == FRM_W'(13)) && (mode == MODE_CRC4) && (eSelect == 2'd0);
  assign eSlot2    = ts0 && (curFrm == FRM_W'(15)) && (mode == MODE_CRC4) && (eSelect == 2'd0);

  always_comb begin
    stb.valid     = inValid;
    stb.ts0       = ts0;
    stb.frm       = curFrm;
    stb.smfStart  = ts0 && (curFrm[2:0] == 3'd0);
    stb.smfEnd    = smfEnd;
    stb.fasInvAll = useFasAll;
    stb.fasInvBit = useFasBit;
    stb.nfasInv   = takeNfas && nfasPend;
    stb.mfasInv   = (curFrm == FRM_W'(1)) ? mfasPend : mfasLatch;
    stb.crcInv    = takeCrc && crcPend;
    stb.eZero     = (curFrm == FRM_W'(13)) ? errPend[0] : errPend[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt      <= '0;
      frmCnt     <= '0;
      fasAllPend <= 1'b0;
      fasBitPend <= 1'b0;
      nfasPend   <= 1'b0;
      mfasPend   <= 1'b0;
      mfasLatch  <= 1'b0;
      crcPend    <= 1'b0;
      errPend    <= '0;
    end else begin
      if (inValid) begin
        tsCnt  <= (curTs == TS_LAST) ? '0 : curTs + TS_W'(1);
        frmCnt <= (curTs == TS_LAST) ? curFrm + FRM_W'(1) : curFrm;
      end
      if (takeMfas) mfasLatch <= mfasPend;
      fasAllPend <= (fasAllPend & ~useFasAll) | invFasWordReq;
      fasBitPend <= (fasBitPend & ~useFasBit) | invFasBitReq;
      nfasPend   <= (nfasPend & ~takeNfas) | invNfasReq;
      mfasPend   <= (mfasPend & ~takeMfas) | invMfasReq;
      crcPend    <= (crcPend & ~takeCrc) | invCrcReq;
      errPend[0] <= (errPend[0] & ~eSlot1) | (rxCrcErr & ~rxCrcErrSmf);
      errPend[1] <= (errPend[1] & ~eSlot2) | (rxCrcErr & rxCrcErrSmf);
    end
  end
endmodule

// File: rtl/e1fr_dp.sv
module e1fr_dp
  import e1fr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  frStrobe_t          stb,
  input  frMode_e            mode,
  input  logic [7:0]         inByte,
  input  logic               siEnable,
  input  logic               siAlign,
  input  logic               siNonAlign,
  input  logic               raiManual,
  input  logic               raiAuto,
  input  logic               rxAlarm,
  input  logic [SA_BITS-1:0] saEnable,
  input  logic [SA_BITS-1:0] saValue,
  input  logic [1:0]         eSelect,
  output logic               outValid,
  output logic [7:0]         outByte
);
  logic [7:0]       txByte, crcByte;
  logic [CRC_W-1:0] crcReg, crcHold, crcNext, crcWork, holdSh;
  logic [5:0]       mfasSh;
  logic             aBit, eBit, fb;

  always_comb begin
    txByte = inByte;
    aBit   = raiManual | (raiAuto & rxAlarm);
    mfasSh = MFAS_WORD << stb.frm[3:1];
    holdSh = crcHold << stb.frm[2:1];
    case (eSelect)
      2'd0:    eBit = ~stb.eZero;
      2'd1:    eBit = (stb.frm == FRM_W'(13)) ? siAlign : siNonAlign;
      default: eBit = inByte[7];
    endcase
    if (stb.ts0 && (mode != MODE_PASS)) begin
      if (!stb.frm[0]) begin
        if (mode == MODE_BASIC) txByte[7] = siEnable ? siAlign : inByte[7];
        else                    txByte[7] = holdSh[CRC_W-1];
        if (mode != MODE_MODCRC)
          txByte[6:0] = FAS_WORD ^ (stb.fasInvAll ? 7'h7f : {6'b0, stb.fasInvBit});
      end else begin
        for (int i = 0; i < SA_BITS; i++)
          if (saEnable[i]) txByte[i] = saValue[i];
        if (mode != MODE_MODCRC) begin
          txByte[6] = ~stb.nfasInv;
          if (aBit) txByte[5] = 1'b1;
          if (mode == MODE_BASIC)            txByte[7] = siEnable ? siNonAlign : inByte[7];
          else if (stb.frm < FRM_W'(12))     txByte[7] = mfasSh[5] ^ stb.mfasInv;
          else                               txByte[7] = eBit;
        end
      end
    end
    crcByte = txByte;
    if (stb.ts0 && !stb.frm[0] && ((mode == MODE_CRC4) || (mode == MODE_MODCRC)))
      crcByte[7] = 1'b0;
    crcWork = stb.smfStart ? '0 : crcReg;
    fb = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      fb      = crcWork[CRC_W-1] ^ crcByte[k];
      crcWork = {crcWork[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crcNext = crcWork;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      crcReg   <= '0;
      crcHold  <= '0;
    end else begin
      outValid <= stb.valid;
      if (stb.valid) begin
        outByte <= txByte;
        crcReg  <= crcNext;
        if (stb.smfEnd) crcHold <= stb.crcInv ? ~crcNext : crcNext;
      end
    end
  end
endmodule

// File: rtl/e1_ts0_framer.sv
module e1_ts0_framer
  import e1fr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               frameSync,
  input  logic [7:0]         inByte,
  input  logic [1:0]         mode,
  input  logic               siEnable,
  input  logic               siAlign,
  input  logic               siNonAlign,
  input  logic               raiManual,
  input  logic               raiAuto,
  input  logic               rxAlarm,
  input  logic [SA_BITS-1:0] saEnable,
  input  logic [SA_BITS-1:0] saValue,
  input  logic [1:0]         eSelect,
  input  logic               rxCrcErr,
  input  logic               rxCrcErrSmf,
  input  logic               invFasBitReq,
  input  logic               invFasWordReq,
  input  logic               invNfasReq,
  input  logic               invMfasReq,
  input  logic               invCrcReq,
  output logic               outValid,
  output logic [7:0]         outByte
);
  frStrobe_t stb;
  frMode_e   modeSel;

  assign modeSel = frMode_e'(mode);

  e1fr_ctrl ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameSync(frameSync),
    .mode(modeSel), .eSelect(eSelect), .rxCrcErr(rxCrcErr), .rxCrcErrSmf(rxCrcErrSmf),
    .invFasBitReq(invFasBitReq), .invFasWordReq(invFasWordReq), .invNfasReq(invNfasReq),
    .invMfasReq(invMfasReq), .invCrcReq(invCrcReq), .stb(stb)
  );

  e1fr_dp dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(modeSel), .inByte(inByte),
    .siEnable(siEnable), .siAlign(siAlign), .siNonAlign(siNonAlign),
    .raiManual(raiManual), .raiAuto(raiAuto), .rxAlarm(rxAlarm),
    .saEnable(saEnable), .saValue(saValue), .eSelect(eSelect),
    .outValid(outValid), .outByte(outByte)
  );
endmodule

// File: rtl/e1fr_chk.sv
module e1fr_chk
  import e1fr_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [7:0]         inByte,
  input logic [1:0]         mode,
  input logic               raiManual,
  input logic [SA_BITS-1:0] saEnable,
  input logic [SA_BITS-1:0] saValue,
  input frStrobe_t          stb,
  input logic               outValid,
  input logic [7:0]         outByte
);
  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  pass_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'd3) |=> (outByte == $past(inByte)));
  // R1
  body_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.valid && !stb.ts0) |=> (outByte == $past(inByte)));
  // R2
  fas_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ts0 && !stb.frm[0] && !mode[1] && !stb.fasInvAll && !stb.fasInvBit)
      |=> (outByte[6:0] == 7'b0011011));
  // R2
  nfas_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ts0 && stb.frm[0] && !mode[1] && !stb.nfasInv) |=> outByte[6]);
  // R4
  rai_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ts0 && stb.frm[0] && !mode[1] && raiManual) |=> outByte[5]);
  // R5
  sa_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ts0 && stb.frm[0] && mode != 2'd3)
      |=> ((outByte[4:0] & $past(saEnable)) == ($past(saValue) & $past(saEnable))));
endmodule

bind e1_ts0_framer e1fr_chk chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .mode(mode),
  .raiManual(raiManual), .saEnable(saEnable), .saValue(saValue), .stb(stb),
  .outValid(outValid), .outByte(outByte)
);

// File: tb/e1_ts0_framer_test.sv
module e1_ts0_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_BYTES  = 1536;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, frameSync = 1'b0;
  logic [7:0] inByte = '0;
  logic [1:0] mode = '0, eSelect = '0;
  logic siEnable = 0, siAlign = 0, siNonAlign = 0;
  logic raiManual = 0, raiAuto = 0, rxAlarm = 0;
  logic [4:0] saEnable = '0, saValue = '0;
  logic rxCrcErr = 0, rxCrcErrSmf = 0;
  logic invFasBitReq = 0, invFasWordReq = 0, invNfasReq = 0, invMfasReq = 0, invCrcReq = 0;
  logic outValid;
  logic [7:0] outByte;

  logic [7:0] sent [0:MAX_BYTES-1];
  logic [7:0] got  [0:MAX_BYTES-1];
  logic       gotV [0:MAX_BYTES-1];
  int total = 0, bad = 0, seed = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ts0_framer uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameSync(frameSync), .inByte(inByte),
    .mode(mode), .siEnable(siEnable), .siAlign(siAlign), .siNonAlign(siNonAlign),
    .raiManual(raiManual), .raiAuto(raiAuto), .rxAlarm(rxAlarm),
    .saEnable(saEnable), .saValue(saValue), .eSelect(eSelect),
    .rxCrcErr(rxCrcErr), .rxCrcErrSmf(rxCrcErrSmf),
    .invFasBitReq(invFasBitReq), .invFasWordReq(invFasWordReq), .invNfasReq(invNfasReq),
    .invMfasReq(invMfasReq), .invCrcReq(invCrcReq),
    .outValid(outValid), .outByte(outByte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int at(input int mf, input int fr, input int ts);
    return (mf * 16 + fr) * 32 + ts;
  endfunction

  function automatic logic mfasBit(input int fr);
    logic [5:0] pat;
    pat = 6'b001011;
    return pat[5 - fr / 2];
  endfunction

  // serial x^4+x+1 remainder over one half-multiframe of observed output
  function automatic logic [3:0] crcOf(input int base);
    logic [3:0] c;
    logic [7:0] b;
    logic f;
    c = '0;
    for (int k = 0; k < 256; k++) begin
      b = got[base + k];
      if ((k % 32 == 0) && ((k / 32) % 2 == 0)) b[7] = 1'b0;
      for (int j = 7; j >= 0; j--) begin
        f = c[3] ^ b[j];
        c = {c[2:0], 1'b0} ^ (f ? 4'b0011 : 4'b0000);
      end
    end
    return c;
  endfunction

  task automatic resetDut();
    @(negedge clk);
    rstN = 0; inValid = 0; frameSync = 0; mode = 0; eSelect = 0;
    siEnable = 0; siAlign = 0; siNonAlign = 0; raiManual = 0; raiAuto = 0; rxAlarm = 0;
    saEnable = 0; saValue = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic runFrames(input int nFr);
    int nB;
    nB = nFr * 32;
    for (int i = 0; i <= nB; i++) begin
      @(negedge clk);
      if (i > 0) begin got[i-1] = outByte; gotV[i-1] = outValid; end
      if (i < nB) begin
        sent[i]   = 8'((i * 29) ^ (seed * 83) ^ (i >> 3));
        inByte    = sent[i];
        inValid   = 1;
        frameSync = (i == 0);
      end else begin
        inValid = 0; frameSync = 0;
      end
    end
    seed++;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    chk(outValid == 0 && outByte == 0, "R1 reset state", {outValid, outByte}, 0);
    rstN = 1;
  endtask

  task automatic testBasic();
    logic [7:0] g, s;
    resetDut();
    mode = 0; siEnable = 1; siAlign = 1; siNonAlign = 0;
    saEnable = 5'b10110; saValue = 5'b00110;
    runFrames(4);
    for (int i = 0; i < 128; i++) begin
      g = got[i]; s = sent[i];
      if (i % 32 != 0) chk(g == s && gotV[i], "R1 body byte", g, s);
      else if ((i / 32) % 2 == 0) begin
        chk(g[6:0] == 7'b0011011, "R2 alignment word", g[6:0], 7'b0011011);
        chk(g[7] == 1'b1, "R3 si align", g[7], 1);
      end else begin
        chk(g[6] == 1'b1, "R2 nfas marker", g[6], 1);
        chk(g[7] == 1'b0, "R3 si non-align", g[7], 0);
        chk(g[5] == s[5], "R4 no alarm passes", g[5], s[5]);
        chk(g[4:0] == ((s[4:0] & ~saEnable) | (saValue & saEnable)), "R5 spare bits",
            g[4:0], (s[4:0] & ~saEnable) | (saValue & saEnable));
      end
    end
    siEnable = 0;
    runFrames(2);
    for (int f = 0; f < 2; f++)
      chk(got[f*32][7] == sent[f*32][7], "R3 si disabled", got[f*32][7], sent[f*32][7]);
    raiManual = 1;
    runFrames(4);
    for (int f = 1; f < 4; f += 2) chk(got[f*32][5] == 1'b1, "R4 manual alarm", got[f*32][5], 1);
    raiManual = 0; raiAuto = 1; rxAlarm = 1;
    runFrames(4);
    for (int f = 1; f < 4; f += 2) chk(got[f*32][5] == 1'b1, "R4 auto alarm", got[f*32][5], 1);
    rxAlarm = 0;
    runFrames(4);
    for (int f = 1; f < 4; f += 2)
      chk(got[f*32][5] == sent[f*32][5], "R4 auto idle", got[f*32][5], sent[f*32][5]);
  endtask

  task automatic testPass();
    resetDut();
    mode = 3; siEnable = 1; raiManual = 1; saEnable = 5'h1f; saValue = 5'h0;
    runFrames(2);
    for (int i = 0; i < 64; i++) chk(got[i] == sent[i] && gotV[i], "R1 pass mode", got[i], sent[i]);
  endtask

  task automatic testCrc();
    logic [3:0] c;
    resetDut();
    mode = 1; eSelect = 0;
    @(negedge clk); rxCrcErr = 1; rxCrcErrSmf = 0;
    @(negedge clk); rxCrcErr = 0;
    runFrames(48);
    for (int mf = 0; mf < 3; mf++) begin
      for (int f = 1; f < 12; f += 2)
        chk(got[at(mf, f, 0)][7] == mfasBit(f), "R6 multiframe pattern", got[at(mf, f, 0)][7], mfasBit(f));
      chk(got[at(mf, 4, 0)][6:0] == 7'b0011011, "R2 word in crc mode", got[at(mf, 4, 0)][6:0], 7'b0011011);
      chk(got[at(mf, 13, 0)][7] == (mf != 0), "R8 E1", got[at(mf, 13, 0)][7], mf != 0);
      chk(got[at(mf, 15, 0)][7] == 1'b1, "R8 E2", got[at(mf, 15, 0)][7], 1);
    end
    for (int s = 1; s < 6; s++) begin
      c = crcOf((s - 1) * 256);
      for (int j = 0; j < 4; j++)
        chk(got[s*256 + j*64][7] == c[3-j], "R7 crc bit", got[s*256 + j*64][7], c[3-j]);
    end
    @(negedge clk); rxCrcErr = 1; rxCrcErrSmf = 1;
    @(negedge clk); rxCrcErr = 0;
    runFrames(16);
    chk(got[at(0, 13, 0)][7] == 1'b1, "R8 E1 untouched", got[at(0, 13, 0)][7], 1);
    chk(got[at(0, 15, 0)][7] == 1'b0, "R8 E2 error zero", got[at(0, 15, 0)][7], 0);
  endtask

  task automatic testESel();
    resetDut();
    mode = 1; eSelect = 1; siAlign = 0; siNonAlign = 1;
    runFrames(16);
    chk(got[at(0, 13, 0)][7] == 1'b0, "R9 E1 from si", got[at(0, 13, 0)][7], 0);
    chk(got[at(0, 15, 0)][7] == 1'b1, "R9 E2 from si", got[at(0, 15, 0)][7], 1);
    siAlign = 1; siNonAlign = 0;
    runFrames(16);
    chk(got[at(0, 13, 0)][7] == 1'b1, "R9 E1 from si", got[at(0, 13, 0)][7], 1);
    chk(got[at(0, 15, 0)][7] == 1'b0, "R9 E2 from si", got[at(0, 15, 0)][7], 0);
    eSelect = 2;
    runFrames(32);
    for (int mf = 0; mf < 2; mf++)
      for (int f = 13; f < 16; f += 2)
        chk(got[at(mf, f, 0)][7] == sent[at(mf, f, 0)][7], "R9 E unchanged",
            got[at(mf, f, 0)][7], sent[at(mf, f, 0)][7]);
  endtask

  task automatic testInv();
    logic [3:0] c;
    resetDut();
    mode = 1; eSelect = 0;
    @(negedge clk); invFasWordReq = 1; invNfasReq = 1; invMfasReq = 1; invCrcReq = 1;
    @(negedge clk); invFasWordReq = 0; invNfasReq = 0; invMfasReq = 0; invCrcReq = 0;
    runFrames(48);
    chk(got[at(0, 0, 0)][6:0] == 7'b1100100, "R10 word inverted", got[at(0, 0, 0)][6:0], 7'b1100100);
    chk(got[at(0, 2, 0)][6:0] == 7'b0011011, "R10 word restored", got[at(0, 2, 0)][6:0], 7'b0011011);
    chk(got[at(0, 1, 0)][6] == 1'b0, "R11 marker inverted", got[at(0, 1, 0)][6], 0);
    chk(got[at(0, 3, 0)][6] == 1'b1, "R11 marker restored", got[at(0, 3, 0)][6], 1);
    for (int f = 1; f < 12; f += 2) begin
      chk(got[at(0, f, 0)][7] == ~mfasBit(f), "R12 pattern inverted", got[at(0, f, 0)][7], ~mfasBit(f));
      chk(got[at(1, f, 0)][7] == mfasBit(f), "R12 pattern restored", got[at(1, f, 0)][7], mfasBit(f));
    end
    c = ~crcOf(0);
    for (int j = 0; j < 4; j++)
      chk(got[256 + j*64][7] == c[3-j], "R13 crc inverted", got[256 + j*64][7], c[3-j]);
    c = crcOf(256);
    for (int j = 0; j < 4; j++)
      chk(got[512 + j*64][7] == c[3-j], "R13 crc restored", got[512 + j*64][7], c[3-j]);
    @(negedge clk); invFasBitReq = 1;
    @(negedge clk); invFasBitReq = 0;
    runFrames(4);
    chk(got[at(0, 0, 0)][6:0] == 7'b0011010, "R10 one bit inverted", got[at(0, 0, 0)][6:0], 7'b0011010);
    chk(got[at(0, 2, 0)][6:0] == 7'b0011011, "R10 bit restored", got[at(0, 2, 0)][6:0], 7'b0011011);
  endtask

  task automatic testMod();
    logic [3:0] c;
    logic [7:0] g, s;
    resetDut();
    mode = 2; siEnable = 1; siAlign = 1; siNonAlign = 1; raiManual = 1;
    saEnable = 5'b01001; saValue = 5'b01000;
    runFrames(32);
    for (int f = 0; f < 32; f++) begin
      g = got[f*32]; s = sent[f*32];
      if (f % 2 == 0) chk(g[6:0] == s[6:0], "R14 even passes", g[6:0], s[6:0]);
      else begin
        chk(g[7:5] == s[7:5], "R14 odd passes", g[7:5], s[7:5]);
        chk(g[4:0] == ((s[4:0] & ~saEnable) | (saValue & saEnable)), "R5 spare in modified",
            g[4:0], (s[4:0] & ~saEnable) | (saValue & saEnable));
      end
    end
    for (int s2 = 1; s2 < 4; s2++) begin
      c = crcOf((s2 - 1) * 256);
      for (int j = 0; j < 4; j++)
        chk(got[s2*256 + j*64][7] == c[3-j], "R7 crc in modified", got[s2*256 + j*64][7], c[3-j]);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    testReset();
    testBasic();
    testPass();
    testCrc();
    testESel();
    testInv();
    testMod();
    finish();
  end
endmodule